// File: doc/BRIEF.md
# Mirrored Configuration Image Integrity Checker

This block verifies a non-volatile configuration image every time the image is loaded: once after reset, and again on each restore command or manufacturer-reset command. The image has three regions of equal length: two copies of the factory region and one user region. The checker reads them in a fixed order through a single-outstanding read port and runs a CRC over each region. When all three scans are done, it updates its fault outputs.

Either factory copy that passes is enough to keep the device running. A disagreement between the two copies raises the integrity fault bit and pulls the alert low. If that disagreement is still present on a check that follows a clear, the unrecoverable flag latches. Only a reset removes that flag. A failing user region, or two failing factory copies, is fatal: the run-enable is held off and the degraded flag is raised. The address logic uses the degraded flag to answer only at 0x7C and at the global addresses 0x5A and 0x5B. The fatal state ends only with a store command followed by a clear.

The read port is a valid/ready request channel. The block raises `mem_req_valid` with `mem_req_addr` and holds both steady until `mem_req_ready` is high on a clock edge. The memory may hold `mem_req_ready` low for any number of cycles. The memory answers each accepted request with exactly one `mem_rsp_valid` pulse. It may answer on any later cycle. The block cannot back-pressure the response, and it issues no new request until the response has arrived.

Top module: `nvm_integrity_checker`

## Requirements
- R1: Leaving reset starts a check at once. `busy` is high during reset and stays high until all three regions are scanned. `run_ok` is low whenever `busy` is high.
- R2: A pulse on `restore_cmd` or `mfr_reset_cmd` while idle starts a check. Such pulses while `busy` is high are ignored: no second check follows.
- R3: Each check requests exactly 3×REGION_BYTES addresses. The order is factory copy A from its base, then copy B, then the user region, offsets ascending. A pending request keeps its valid and address until it is accepted.
- R4: A region passes when the CRC-16 of its body equals its last two bytes, stored high byte first. The CRC uses polynomial 0x1021, start value 0xFFFF, no reflection and no final XOR.
- R5: `nvm_crc_fault` and `degraded` only become set on the edge where `busy` falls.
- R6: Exactly one failing factory copy sets `nvm_crc_fault` and drives `alert_n` low. `run_ok` stays high and `degraded` stays low.
- R7: A failing user region sets `nvm_crc_fault` and `status_mfr`, drives `alert_n` low and `run_ok` low, and raises `degraded`.
- R8: Two failing factory copies are fatal in the same way as R7.
- R9: A pulse on `clear_cmd` or `fault_w1c` clears `nvm_crc_fault`. A fatal condition survives such a clear while no store has been issued.
- R10: A factory-copy disagreement found by a check that follows a clear of an earlier disagreement sets `unrecoverable`. This flag ignores every clear and holds `alert_n` and `status_mfr` asserted.
- R11: When a clear arrives in the same cycle that a check completes, the result of the check wins.
- R12: A `store_cmd` pulse during a fatal condition, followed by a clear, removes it: `run_ok` returns high and `degraded` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release acts as power-on |
| restore_cmd | input | 1 | Pulse: reload-all command, triggers a check |
| mfr_reset_cmd | input | 1 | Pulse: manufacturer reset command, triggers a check |
| store_cmd | input | 1 | Pulse: a good configuration has been stored |
| clear_cmd | input | 1 | Pulse: clear-faults command |
| fault_w1c | input | 1 | Pulse: a 1 written to the integrity fault bit |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per accepted request |
| mem_rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Check in progress |
| nvm_crc_fault | output | 1 | Integrity fault bit of the manufacturer status |
| status_mfr | output | 1 | Manufacturer summary bit of status byte/word |
| unrecoverable | output | 1 | Sticky irrecoverable factory-region fault |
| alert_n | output | 1 | Active-low alert |
| run_ok | output | 1 | Low pulls the run enable low |
| degraded | output | 1 | Restricts bus responses to the fallback addresses |

## Verification
Check completion and a fault clear can land in the same cycle. That case decides whether the fault outputs of a fresh failure survive. The bench holds `clear_cmd` high from reset release through the whole scan of an image with a corrupt user region, so the clear is present on the completion edge. It then expects the fault, alert and degraded outputs of R7 as if no clear had arrived. The memory model also stalls `mem_req_ready` in a pseudo-random pattern, so every region is scanned under back-pressure.

// File: rtl/nvm_chk_pkg.sv
package nvm_chk_pkg;

  localparam int NUM_REGIONS = 3;
  localparam int RGN_A = 0;
  localparam int RGN_B = 1;
  localparam int RGN_U = 2;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_FIN  = 2'd3
  } sq_state_t;

  // One byte through CRC-16, polynomial 0x1021, MSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

endpackage

// File: rtl/nvm_chk_seq.sv
module nvm_chk_seq
  import nvm_chk_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int REGION_BYTES = 16,
  parameter int BASE_A       = 0,
  parameter int BASE_B       = 64,
  parameter int BASE_U       = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  output logic              byte_first,
  output logic              byte_last,
  output logic [1:0]        byte_region,
  output logic              done,
  output logic              busy
);

  localparam int OFF_W = $clog2(REGION_BYTES);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(REGION_BYTES - 1);

  sq_state_t        state;
  logic [1:0]       region;
  logic [OFF_W-1:0] off;
  logic [ADDR_W-1:0] base;

  always_comb begin
    case (region)
      2'd0:    base = ADDR_W'(BASE_A);
      2'd1:    base = ADDR_W'(BASE_B);
      default: base = ADDR_W'(BASE_U);
    endcase
  end

  // Reset parks the sequencer in SQ_REQ so the power-on check starts at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_REQ;
      region <= 2'd0;
      off    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_REQ;
          region <= 2'd0;
          off    <= '0;
        end
        SQ_REQ: if (mem_req_ready) state <= SQ_WAIT;
        SQ_WAIT: if (mem_rsp_valid) begin
          if (off == OFF_LAST) begin
            off <= '0;
            if (region == 2'(NUM_REGIONS - 1)) state <= SQ_FIN;
            else begin
              region <= region + 2'd1;
              state  <= SQ_REQ;
            end
          end else begin
            off   <= off + 1'b1;
            state <= SQ_REQ;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state == SQ_REQ);
  assign mem_req_addr  = base + ADDR_W'(off);
  assign byte_valid    = (state == SQ_WAIT) && mem_rsp_valid;
  assign byte_data     = mem_rsp_data;
  assign byte_first    = (off == '0);
  assign byte_last     = (off == OFF_LAST);
  assign byte_region   = region;
  assign done          = (state == SQ_FIN);
  assign busy          = (state != SQ_IDLE);

endmodule

// File: rtl/nvm_chk_crc.sv
module nvm_chk_crc
  import nvm_chk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_valid,
  input  logic [7:0]             byte_data,
  input  logic                   byte_first,
  input  logic                   byte_last,
  input  logic [1:0]             byte_region,
  output logic [NUM_REGIONS-1:0] region_bad
);

  logic [15:0] crc_q;
  logic [15:0] crc_nxt;

  // Stored CRC is appended high byte first, so a clean region leaves residue 0.
  assign crc_nxt = crc16_step(byte_first ? 16'hFFFF : crc_q, byte_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= 16'hFFFF;
    else if (byte_valid) crc_q <= crc_nxt;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_verdict
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        region_bad[g] <= 1'b0;
      else if (byte_valid && byte_last && (byte_region == 2'(g)))
        region_bad[g] <= (crc_nxt != 16'h0000);
    end
  end

endmodule

// File: rtl/nvm_chk_status.sv
module nvm_chk_status
  import nvm_chk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done,
  input  logic [NUM_REGIONS-1:0] region_bad,
  input  logic                   clr,
  input  logic                   store,
  output logic                   fault,
  output logic                   fatal,
  output logic                   unrec
);

  logic mismatch, both_bad, fatal_now;
  logic mm_hist;     // last check saw a copy disagreement
  logic mm_cleared;  // that disagreement has since been cleared
  logic repaired;    // store seen while fatal

  assign mismatch  = region_bad[RGN_A] ^ region_bad[RGN_B];
  assign both_bad  = region_bad[RGN_A] & region_bad[RGN_B];
  assign fatal_now = region_bad[RGN_U] | both_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      fatal      <= 1'b0;
      unrec      <= 1'b0;
      mm_hist    <= 1'b0;
      mm_cleared <= 1'b0;
      repaired   <= 1'b0;
    end else if (done) begin
      // Completion outranks a clear arriving in the same cycle.
      fault      <= fault | mismatch | fatal_now;
      fatal      <= fatal_now;
      if (mismatch && mm_cleared) unrec <= 1'b1;
      mm_hist    <= mismatch;
      mm_cleared <= 1'b0;
      repaired   <= 1'b0;
    end else begin
      if (store && fatal) repaired <= 1'b1;
      if (clr) begin
        fault <= 1'b0;
        if (mm_hist) mm_cleared <= 1'b1;
        if (fatal && (repaired || store)) begin
          fatal    <= 1'b0;
          repaired <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/nvm_integrity_checker.sv
module nvm_integrity_checker
  import nvm_chk_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int REGION_BYTES = 16,
  parameter int BASE_A       = 0,
  parameter int BASE_B       = 64,
  parameter int BASE_U       = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restore_cmd,
  input  logic              mfr_reset_cmd,
  input  logic              store_cmd,
  input  logic              clear_cmd,
  input  logic              fault_w1c,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_data,
  output logic              busy,
  output logic              nvm_crc_fault,
  output logic              status_mfr,
  output logic              unrecoverable,
  output logic              alert_n,
  output logic              run_ok,
  output logic              degraded
);

  logic                   start, done;
  logic                   b_valid, b_first, b_last;
  logic [7:0]             b_data;
  logic [1:0]             b_region;
  logic [NUM_REGIONS-1:0] region_bad;
  logic                   fatal;

  assign start = restore_cmd | mfr_reset_cmd;

  nvm_chk_seq #(
    .ADDR_W(ADDR_W), .REGION_BYTES(REGION_BYTES),
    .BASE_A(BASE_A), .BASE_B(BASE_B), .BASE_U(BASE_U)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .byte_valid(b_valid), .byte_data(b_data),
    .byte_first(b_first), .byte_last(b_last), .byte_region(b_region),
    .done(done), .busy(busy)
  );

  nvm_chk_crc u_crc (
    .clk(clk), .rst_n(rst_n), .byte_valid(b_valid), .byte_data(b_data),
    .byte_first(b_first), .byte_last(b_last), .byte_region(b_region),
    .region_bad(region_bad)
  );

  nvm_chk_status u_stat (
    .clk(clk), .rst_n(rst_n), .done(done), .region_bad(region_bad),
    .clr(clear_cmd | fault_w1c), .store(store_cmd),
    .fault(nvm_crc_fault), .fatal(fatal), .unrec(unrecoverable)
  );

  assign status_mfr = nvm_crc_fault | unrecoverable;
  assign alert_n    = ~status_mfr;
  assign run_ok     = ~busy & ~fatal;
  assign degraded   = fatal;

endmodule

// File: rtl/nvm_integrity_checker_props.sv
module nvm_integrity_checker_props #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              busy,
  input logic              nvm_crc_fault,
  input logic              unrecoverable,
  input logic              alert_n,
  input logic              run_ok,
  input logic              degraded
);

  p_run_off_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !run_ok);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_fault_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nvm_crc_fault) |-> $fell(busy));

  p_degraded_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(degraded) |-> $fell(busy));

  p_alert_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_crc_fault || unrecoverable) |-> !alert_n);

  p_degraded_no_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |-> !run_ok);

  p_unrec_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unrecoverable |=> unrecoverable);

endmodule

bind nvm_integrity_checker nvm_integrity_checker_props #(.ADDR_W(ADDR_W)) u_props (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .busy(busy),
  .nvm_crc_fault(nvm_crc_fault), .unrecoverable(unrecoverable),
  .alert_n(alert_n), .run_ok(run_ok), .degraded(degraded)
);

// File: tb/nvm_integrity_checker_test.sv
`timescale 1ns/1ps
module nvm_integrity_checker_test;

  localparam int AW = 10;
  localparam int RB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restore_cmd = 0, mfr_reset_cmd = 0, store_cmd = 0, clear_cmd = 0, fault_w1c = 0;
  logic mem_req_valid, mem_req_ready = 0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 0;
  logic [7:0] mem_rsp_data = 0;
  logic busy, nvm_crc_fault, status_mfr, unrecoverable, alert_n, run_ok, degraded;

  always #2.5 clk = ~clk;

  nvm_integrity_checker uut (.*);

  logic [7:0] mem [0:255];
  logic [7:0] lfsr = 8'hA5;

  // Memory model: stalls ready pseudo-randomly, answers one cycle after acceptance.
  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[7:0]];
    end else
      mem_rsp_valid <= 1'b0;
  end

  int n_chk = 0, n_fail = 0;
  logic [4:0] exp_q[$];   // {fault, unrec, alert_n, run_ok, degraded}
  int hs_cnt = 0, addr_err = 0;
  logic prev_busy = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int base);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < RB - 2; i++)
      for (int b = 7; b >= 0; b--) begin
        logic top = c[15] ^ mem[base + i][b];
        c = {c[14:0], 1'b0} ^ (top ? 16'h1021 : 16'h0000);
      end
    return c;
  endfunction

  task automatic fill_image();
    for (int r = 0; r < 3; r++) begin
      logic [15:0] c;
      for (int i = 0; i < RB - 2; i++) mem[r * 64 + i] = 8'(r * 37 + i * 11 + 5);
      c = ref_crc(r * 64);
      mem[r * 64 + RB - 2] = c[15:8];
      mem[r * 64 + RB - 1] = c[7:0];
    end
  endtask

  task automatic corrupt(input int r);
    mem[r * 64 + 3] = mem[r * 64 + 3] ^ 8'h10;
  endtask

  task automatic push_exp(input logic [4:0] v);
    exp_q.push_back(v);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: restore_cmd = 1;  1: mfr_reset_cmd = 1;  2: store_cmd = 1;
      3: clear_cmd = 1;    default: fault_w1c = 1;
    endcase
    @(negedge clk);
    {restore_cmd, mfr_reset_cmd, store_cmd, clear_cmd, fault_w1c} = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  // Monitor: address order and scoreboard comparison on each completion.
  always @(negedge clk) begin
    if (!rst_n) begin
      hs_cnt = 0; addr_err = 0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (int'(mem_req_addr) != (hs_cnt / RB) * 64 + hs_cnt % RB) addr_err++;
      hs_cnt++;
    end
    if (prev_busy && !busy && rst_n) begin
      check(hs_cnt == 3 * RB && addr_err == 0, "R3", "request count/order",
            hs_cnt, 3 * RB);
      hs_cnt = 0; addr_err = 0;
      if (exp_q.size() == 0)
        check(0, "R2", "unexpected completion", 1, 0);
      else begin
        logic [4:0] e, a;
        e = exp_q.pop_front();
        a = {nvm_crc_fault, unrecoverable, alert_n, run_ok, degraded};
        check(a == e, "R4", "status after check", a, e);
      end
    end
    prev_busy = busy;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    fill_image();
    push_exp(5'b00110);
    repeat (3) @(negedge clk);
    check(busy && !run_ok, "R1", "busy/run in reset", {busy, run_ok}, 2'b10);
    check(alert_n && !nvm_crc_fault && !degraded, "R1", "reset faults clear",
          {alert_n, nvm_crc_fault, degraded}, 3'b100);
    rst_n = 1;
    wait_idle();
    check(run_ok == 1, "R1", "run after clean check", run_ok, 1);

    // R6 single bad factory copy, with R5 mid-check and R2 ignored trigger
    corrupt(0);
    push_exp(5'b10010);
    pulse(0);
    repeat (10) @(negedge clk);
    check(busy && !nvm_crc_fault, "R5", "fault during scan", nvm_crc_fault, 0);
    pulse(1);
    wait_idle();
    repeat (40) @(negedge clk);
    check(!busy, "R2", "no check after ignored trigger", busy, 0);

    // R9 clear by write-one
    pulse(4);
    check(!nvm_crc_fault && alert_n, "R9", "w1c clears fault",
          {nvm_crc_fault, alert_n}, 2'b01);

    // R10 disagreement again after clear
    push_exp(5'b11010);
    pulse(1);
    wait_idle();
    pulse(3);
    check(!nvm_crc_fault && unrecoverable && !alert_n && status_mfr, "R10",
          "unrecoverable survives clear",
          {nvm_crc_fault, unrecoverable, alert_n, status_mfr}, 4'b0101);

    // R7 user region bad
    @(negedge clk); rst_n = 0;
    fill_image(); corrupt(2);
    push_exp(5'b10001);
    repeat (2) @(negedge clk); rst_n = 1;
    wait_idle();
    check(status_mfr == 1, "R7", "status mfr bit", status_mfr, 1);
    pulse(3);
    check(!nvm_crc_fault && degraded && !run_ok, "R9", "fatal survives clear",
          {nvm_crc_fault, degraded, run_ok}, 3'b010);

    // R12 store then clear repairs
    pulse(2);
    check(degraded && !run_ok, "R12", "store alone keeps fatal", {degraded, run_ok}, 2'b10);
    pulse(3);
    check(!degraded && run_ok && alert_n, "R12", "repaired",
          {degraded, run_ok, alert_n}, 3'b011);

    // R8 both factory copies bad
    fill_image(); corrupt(0); corrupt(1);
    push_exp(5'b10001);
    pulse(0);
    wait_idle();

    // R11 clear held through completion
    @(negedge clk); rst_n = 0;
    fill_image(); corrupt(2);
    push_exp(5'b10001);
    repeat (2) @(negedge clk);
    clear_cmd = 1; rst_n = 1;
    wait_idle();
    clear_cmd = 0;
    check(nvm_crc_fault && degraded, "R11", "completion beats clear",
          {nvm_crc_fault, degraded}, 2'b11);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all expected checks seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule